// File: doc/BRIEF.md
# PHY Link Poller and Mode Resolver

This block watches the link state of a set of external Ethernet PHYs (two by default) by reading their management registers on a fixed schedule. It does this through a single-request MDIO port, and it drives per-port link-up, speed, duplex and pause outputs that the MAC side of a switch uses to configure itself. Each poll round visits the ports in ascending order. A port is fully examined only when its link bit has moved since the last time that port was examined.

When a link appears to drop, the block clears that port's link-up output at once. It then reads the status register a second time, because the PHY holds the link bit low until it has been read. The block acts on the fresh value. When a link is up, the block chooses between two ways of setting the port mode:

- **Negotiated mode:** used only if autonegotiation is both enabled and complete. The block picks the best mode both partners share, trying in order 1000M full, 1000M half, 100M full, 100M half, 10M full and 10M half.
- **Forced mode:** used otherwise. The block takes the mode from the PHY's control register.

Top module: `phy_link_poller`

## Requirements
- R1: A poll round starts every PERIOD_CYC clock cycles. It reads port 0 first, then port 1, and port p uses PHY address PHY_BASE+p. Every request is a read, with `mdio_op` = 2'b10.
- R2: If `sw_en` is low when the round timer expires, that round issues no MDIO request.
- R3: If status register 1 reads 16'h0000 or 16'hFFFF, the port counts as absent. The block reads nothing more from it in that round and leaves all of its outputs unchanged.
- R4: The port is processed further only when bit 2 of register 1 differs from that port's stored link state. After reset the stored state is unknown, so the first answer from a present PHY is always processed. An unchanged port receives no further reads and its outputs do not change.
- R5: When bit 2 reads 0, the block clears the port's `link_up` and reads register 1 again. If the second read also shows bit 2 at 0, the port stays down and the block reads nothing more. If the second read shows the link up, the block resolves the mode from the second value.
- R6: Negotiated mode applies only when register 0 bit 12 and register 1 bit 5 are both set. In that case the block reads registers 0, 4, 5, 9 and 10. Otherwise it reads only registers 0 and 4.
- R7: In negotiated mode, pause is register 4 bit 10 AND register 5 bit 10.
- R8: In negotiated mode, the block selects the first matching entry below. Speed is encoded as 2 = 1000M, 1 = 100M, 0 = 10M, and the value 3 never appears.
  - r9[9] & r10[11]: 1000M full.
  - r9[8] & r10[10]: 1000M half.
  - r4[8] & r5[8]: 100M full.
  - r4[7] & r5[7]: 100M half.
  - r4[6] & r5[6]: 10M full.
  - No match: 10M half.
- R9: In forced mode, the port outputs are set as follows:
  - Pause is register 4 bit 10.
  - Speed is 2 if register 0 bit 6 is set, and otherwise equals register 0 bit 13.
  - Duplex is register 0 bit 8.
- R10: After a link-up resolution, speed, duplex and pause change one cycle before `link_up` rises. None of them changes in the cycle that `link_up` rises.
- R11: At most one request is outstanding. `mdio_req` is a single-cycle pulse and is never asserted while `mdio_busy` is high.
- R12: During reset and before the first round, `mdio_req` and all port outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_en | input | 1 | Switch enable; a poll round is skipped while low |
| mdio_req | output | 1 | One-cycle request pulse to the MDIO master |
| mdio_op | output | 2 | Request opcode, always read (2'b10) |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register address of the request |
| mdio_busy | input | 1 | High while the MDIO master is executing a request; must rise the cycle after mdio_req |
| mdio_rdata | input | 16 | Read data, valid while mdio_busy is low after a request |
| link_up | output | NUM_PORTS | Per-port link-up flag |
| port_speed | output | 2*NUM_PORTS | Per-port speed code, two bits per port |
| port_duplex | output | NUM_PORTS | Per-port full duplex flag |
| port_pause | output | NUM_PORTS | Per-port flow-control enable |

## Verification
The bench goes after several corner cases, each of which would show up as a specific fault:

- **Latched-low re-read.** A link that reads down and then up on the second read must come back up with a resolved mode. A design that skipped the second read would leave the port down for a whole poll period.
- **Absent and unchanged ports.** A design that ignored the absent codes, or the stored link state, would issue extra reads that the per-port read counts expose. It could also overwrite a port's mode.
- **Autonegotiation condition.** Random register contents make autonegotiation enabled-but-incomplete and complete-but-disabled common. A design that tested only one of the two bits would take the negotiated path and read registers 9 and 10 when it should not.
- **Resolution priority.** Shared-capability patterns at every priority level catch an inverted priority or a swapped duplex bit.
- **Skipped rounds.** A round with the enable input low must issue no requests at all, and the round phase must not drift.

// File: rtl/plp_pkg.sv
package plp_pkg;

    localparam logic [1:0] OP_READ = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_APPLY,
        ST_LINK,
        ST_NEXT
    } st_e;

    typedef enum logic [2:0] {
        RD_STAT,
        RD_RESTAT,
        RD_CTL,
        RD_ADV,
        RD_LPA,
        RD_GCTL,
        RD_GSTAT
    } rd_e;

    // Only the register bits the resolution uses are kept.
    typedef struct packed {
        logic       an_en;   // ctl bit 12
        logic       an_done; // status bit 5
        logic       f_gig;   // ctl bit 6
        logic       f_100;   // ctl bit 13
        logic       f_full;  // ctl bit 8
        logic [3:0] adv;     // {adv[10], adv[8:6]}
        logic [3:0] lpa;     // {lpa[10], lpa[8:6]}
        logic [1:0] gadv;    // gig control bits 9:8
        logic [1:0] glpa;    // gig status bits 11:10
    } caps_t;

    typedef struct packed {
        logic [1:0] speed;
        logic       duplex;
        logic       pause;
    } mode_t;

    function automatic logic [4:0] reg_of(rd_e r);
        case (r)
            RD_STAT, RD_RESTAT: return 5'd1;
            RD_CTL:             return 5'd0;
            RD_ADV:             return 5'd4;
            RD_LPA:             return 5'd5;
            RD_GCTL:            return 5'd9;
            default:            return 5'd10;
        endcase
    endfunction

endpackage

// File: rtl/plp_tick.sv
module plp_tick #(
    parameter int PERIOD_CYC = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/plp_resolve.sv
module plp_resolve
    import plp_pkg::*;
(
    input  caps_t caps,
    output mode_t mode
);
    logic [1:0] gm;
    logic [2:0] cm;

    always_comb begin
        gm   = caps.gadv & caps.glpa;
        cm   = caps.adv[2:0] & caps.lpa[2:0];
        mode = '0;
        if (caps.an_en && caps.an_done) begin
            mode.pause = caps.adv[3] & caps.lpa[3];
            if (gm[1])      begin mode.speed = 2'd2; mode.duplex = 1'b1; end
            else if (gm[0]) begin mode.speed = 2'd2; mode.duplex = 1'b0; end
            else if (cm[2]) begin mode.speed = 2'd1; mode.duplex = 1'b1; end
            else if (cm[1]) begin mode.speed = 2'd1; mode.duplex = 1'b0; end
            else if (cm[0]) begin mode.speed = 2'd0; mode.duplex = 1'b1; end
            else            begin mode.speed = 2'd0; mode.duplex = 1'b0; end
        end else begin
            mode.pause  = caps.adv[3];
            mode.speed  = caps.f_gig ? 2'd2 : {1'b0, caps.f_100};
            mode.duplex = caps.f_full;
        end
    end
endmodule

// File: rtl/phy_link_poller.sv
module phy_link_poller
    import plp_pkg::*;
#(
    parameter int NUM_PORTS  = 2,
    parameter int PHY_BASE   = 0,
    parameter int PERIOD_CYC = 100_000_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sw_en,
    output logic                   mdio_req,
    output logic [1:0]             mdio_op,
    output logic [4:0]             mdio_phy,
    output logic [4:0]             mdio_reg,
    input  logic                   mdio_busy,
    input  logic [15:0]            mdio_rdata,
    output logic [NUM_PORTS-1:0]   link_up,
    output logic [2*NUM_PORTS-1:0] port_speed,
    output logic [NUM_PORTS-1:0]   port_duplex,
    output logic [NUM_PORTS-1:0]   port_pause
);
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [PW-1:0] LAST_PORT = PW'(NUM_PORTS - 1);

    typedef struct packed {
        st_e                       st;
        rd_e                       rd;
        logic [PW-1:0]             port;
        caps_t                     caps;
        logic [NUM_PORTS-1:0]      link;
        logic [NUM_PORTS-1:0]      dup;
        logic [NUM_PORTS-1:0]      pause;
        logic [NUM_PORTS-1:0]      known;
        logic [NUM_PORTS-1:0]      prev;
        logic [NUM_PORTS-1:0][1:0] speed;
    } state_t;

    state_t s_d, s_q;
    logic   tick;
    mode_t  res;
    logic   absent;

    plp_tick #(.PERIOD_CYC(PERIOD_CYC)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    plp_resolve res_i (
        .caps (s_q.caps),
        .mode (res)
    );

    assign mdio_req    = (s_q.st == ST_ISSUE);
    assign mdio_op     = OP_READ;
    assign mdio_phy    = 5'(PHY_BASE) + 5'(s_q.port);
    assign mdio_reg    = reg_of(s_q.rd);
    assign link_up     = s_q.link;
    assign port_speed  = s_q.speed;
    assign port_duplex = s_q.dup;
    assign port_pause  = s_q.pause;
    assign absent      = (mdio_rdata == 16'h0000) || (mdio_rdata == 16'hFFFF);

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (tick && sw_en) begin
                    s_d.port = '0;
                    s_d.rd   = RD_STAT;
                    s_d.st   = ST_ISSUE;
                end
            end
            ST_ISSUE: s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (!mdio_busy) begin
                    s_d.st = ST_ISSUE;
                    case (s_q.rd)
                        RD_STAT: begin
                            s_d.caps.an_done = mdio_rdata[5];
                            if (absent) begin
                                s_d.st = ST_NEXT;
                            end else if (s_q.known[s_q.port] &&
                                         (s_q.prev[s_q.port] == mdio_rdata[2])) begin
                                s_d.st = ST_NEXT;
                            end else if (!mdio_rdata[2]) begin
                                s_d.link[s_q.port] = 1'b0;
                                s_d.rd = RD_RESTAT;
                            end else begin
                                s_d.rd = RD_CTL;
                            end
                        end
                        RD_RESTAT: begin
                            s_d.caps.an_done = mdio_rdata[5];
                            if (!mdio_rdata[2]) begin
                                s_d.prev[s_q.port]  = 1'b0;
                                s_d.known[s_q.port] = 1'b1;
                                s_d.st = ST_NEXT;
                            end else begin
                                s_d.rd = RD_CTL;
                            end
                        end
                        RD_CTL: begin
                            s_d.caps.an_en  = mdio_rdata[12];
                            s_d.caps.f_gig  = mdio_rdata[6];
                            s_d.caps.f_100  = mdio_rdata[13];
                            s_d.caps.f_full = mdio_rdata[8];
                            s_d.rd = RD_ADV;
                        end
                        RD_ADV: begin
                            s_d.caps.adv = {mdio_rdata[10], mdio_rdata[8:6]};
                            if (s_q.caps.an_en && s_q.caps.an_done) s_d.rd = RD_LPA;
                            else                                    s_d.st = ST_APPLY;
                        end
                        RD_LPA: begin
                            s_d.caps.lpa = {mdio_rdata[10], mdio_rdata[8:6]};
                            s_d.rd = RD_GCTL;
                        end
                        RD_GCTL: begin
                            s_d.caps.gadv = mdio_rdata[9:8];
                            s_d.rd = RD_GSTAT;
                        end
                        default: begin
                            s_d.caps.glpa = mdio_rdata[11:10];
                            s_d.st = ST_APPLY;
                        end
                    endcase
                end
            end
            ST_APPLY: begin
                s_d.speed[s_q.port] = res.speed;
                s_d.dup[s_q.port]   = res.duplex;
                s_d.pause[s_q.port] = res.pause;
                s_d.st = ST_LINK;
            end
            ST_LINK: begin
                s_d.link[s_q.port]  = 1'b1;
                s_d.prev[s_q.port]  = 1'b1;
                s_d.known[s_q.port] = 1'b1;
                s_d.st = ST_NEXT;
            end
            default: begin
                if (s_q.port == LAST_PORT) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.port = s_q.port + 1'b1;
                    s_d.rd   = RD_STAT;
                    s_d.st   = ST_ISSUE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
            s_q.rd <= RD_STAT;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/plp_checker.sv
module plp_checker #(
    parameter int NUM_PORTS = 2,
    parameter int PHY_BASE  = 0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mdio_req,
    input logic                   mdio_busy,
    input logic [4:0]             mdio_phy,
    input logic [NUM_PORTS-1:0]   link_up,
    input logic [2*NUM_PORTS-1:0] port_speed,
    input logic [NUM_PORTS-1:0]   port_duplex,
    input logic [NUM_PORTS-1:0]   port_pause
);
    a_r11_no_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_busy |-> !mdio_req);

    a_r11_req_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req |=> !mdio_req);

    a_r1_phy_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req |-> ((int'(mdio_phy) >= PHY_BASE) && (int'(mdio_phy) < PHY_BASE + NUM_PORTS)));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        a_r8_speed_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
            port_speed[2*p +: 2] != 2'b11);

        a_r10_mode_before_link: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(link_up[p]) |-> ($stable(port_speed[2*p +: 2]) &&
                                   $stable(port_duplex[p]) && $stable(port_pause[p])));
    end
endmodule

bind phy_link_poller plp_checker #(
    .NUM_PORTS (NUM_PORTS),
    .PHY_BASE  (PHY_BASE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mdio_req    (mdio_req),
    .mdio_busy   (mdio_busy),
    .mdio_phy    (mdio_phy),
    .link_up     (link_up),
    .port_speed  (port_speed),
    .port_duplex (port_duplex),
    .port_pause  (port_pause)
);

// File: tb/phy_link_poller_tb_top.sv
`timescale 1ns/1ps
module phy_link_poller_tb_top;
    localparam int NP     = 2;
    localparam int PHY0   = 4;
    localparam int PERIOD = 800;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_en = 1'b1;
    logic mdio_req;
    logic [1:0] mdio_op;
    logic [4:0] mdio_phy, mdio_reg;
    logic mdio_busy;
    logic [15:0] mdio_rdata;
    logic [NP-1:0] link_up, port_duplex, port_pause;
    logic [2*NP-1:0] port_speed;

    always #2.5 clk = ~clk;

    phy_link_poller #(.NUM_PORTS(NP), .PHY_BASE(PHY0), .PERIOD_CYC(PERIOD)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_en(sw_en),
        .mdio_req(mdio_req), .mdio_op(mdio_op), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
        .mdio_busy(mdio_busy), .mdio_rdata(mdio_rdata),
        .link_up(link_up), .port_speed(port_speed), .port_duplex(port_duplex),
        .port_pause(port_pause)
    );

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- PHY / MDIO master model ----------------
    logic [15:0] m_r0[NP], m_r1a[NP], m_r1b[NP], m_r4[NP], m_r5[NP], m_r9[NP], m_r10[NP];
    int round_id = 1;
    int seen_id[NP] = '{0, 0};
    int lat_cnt = 0;
    logic [15:0] pend = '0;
    logic [15:0] rd_q = '0;
    logic busy_q = 1'b0;

    assign mdio_busy  = busy_q;
    assign mdio_rdata = rd_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            lat_cnt <= 0;
        end else if (mdio_req) begin
            int p;
            p = int'(mdio_phy) - PHY0;
            busy_q <= 1'b1;
            lat_cnt <= LAT;
            if (p >= 0 && p < NP) begin
                case (mdio_reg)
                    5'd0:  pend <= m_r0[p];
                    5'd1: begin
                        if (seen_id[p] != round_id) begin
                            pend <= m_r1a[p];
                            seen_id[p] = round_id;
                        end else pend <= m_r1b[p];
                    end
                    5'd4:  pend <= m_r4[p];
                    5'd5:  pend <= m_r5[p];
                    5'd9:  pend <= m_r9[p];
                    5'd10: pend <= m_r10[p];
                    default: pend <= 16'h0;
                endcase
            end else pend <= 16'h0;
        end else if (busy_q) begin
            if (lat_cnt == 0) begin
                busy_q <= 1'b0;
                rd_q <= pend;
            end else lat_cnt <= lat_cnt - 1;
        end
    end

    // ---------------- monitor ----------------
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_req = 0;
    int last_req_cyc = -100000;
    int last_start = -1;
    int last_p = 0;
    int mon_id = 0;
    int reads[NP];
    int r9_reads[NP];
    logic [NP-1:0] prv_link = '0;
    logic [2*NP-1:0] prv_spd = '0;
    logic [NP-1:0] prv_dup = '0, prv_pau = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_id != round_id) begin
                for (int i = 0; i < NP; i++) begin reads[i] = 0; r9_reads[i] = 0; end
                mon_id = round_id;
            end
            if (mdio_req) begin
                int p;
                p = int'(mdio_phy) - PHY0;
                n_req++;
                // R11: one outstanding request, read opcode
                chk(!mdio_busy && mdio_op == 2'b10, "R11", "request while busy or wrong op",
                    {mdio_busy, mdio_op}, 2);
                if (cyc - last_req_cyc > 100) begin
                    // R1: round start aligned to the period, port 0 status first
                    if (last_start >= 0)
                        chk(((cyc - last_start) % PERIOD == 0) && p == 0 && mdio_reg == 5'd1,
                            "R1", "round start spacing", cyc - last_start, PERIOD);
                    last_start = cyc;
                end else if (p < last_p) begin
                    chk(1'b0, "R1", "port order within round", p, last_p);
                end
                last_p = p;
                last_req_cyc = cyc;
                if (p >= 0 && p < NP) begin
                    reads[p]++;
                    if (mdio_reg == 5'd9) r9_reads[p]++;
                end
            end
            for (int p = 0; p < NP; p++) begin
                if (link_up[p] && !prv_link[p])
                    chk(port_speed[2*p +: 2] == prv_spd[2*p +: 2] &&
                        port_duplex[p] == prv_dup[p] && port_pause[p] == prv_pau[p],
                        "R10", "mode moved with link rise", int'(port_speed[2*p +: 2]),
                        int'(prv_spd[2*p +: 2]));
            end
        end
        prv_link = link_up;
        prv_spd  = port_speed;
        prv_dup  = port_duplex;
        prv_pau  = port_pause;
    end

    // ---------------- reference model ----------------
    bit e_known[NP] = '{0, 0};
    bit e_prev[NP]  = '{0, 0};
    bit e_link[NP]  = '{0, 0};
    bit [1:0] e_spd[NP] = '{2'd0, 2'd0};
    bit e_dup[NP] = '{0, 0};
    bit e_pau[NP] = '{0, 0};
    int e_reads[NP];
    int e_r9[NP];
    string t_rd[NP], t_md[NP], t_pa[NP], t_ln[NP];

    function automatic bit [3:0] ref_mode(input bit [15:0] r0, r1, r4, r5, r9, r10);
        bit [1:0] sp;
        bit du, pa;
        if (r0[12] && r1[5]) begin
            pa = r4[10] & r5[10];
            if (r9[9] & r10[11])     begin sp = 2; du = 1; end
            else if (r9[8] & r10[10]) begin sp = 2; du = 0; end
            else if (r4[8] & r5[8])   begin sp = 1; du = 1; end
            else if (r4[7] & r5[7])   begin sp = 1; du = 0; end
            else if (r4[6] & r5[6])   begin sp = 0; du = 1; end
            else                      begin sp = 0; du = 0; end
        end else begin
            pa = r4[10];
            sp = r0[6] ? 2'd2 : {1'b0, r0[13]};
            du = r0[8];
        end
        return {sp, du, pa};
    endfunction

    task automatic predict(input int p);
        bit [15:0] r1;
        bit lk, neg;
        bit [3:0] m;
        e_reads[p] = 1;
        e_r9[p] = 0;
        r1 = m_r1a[p];
        if (r1 == 16'h0000 || r1 == 16'hFFFF) begin
            t_rd[p] = "R3"; t_md[p] = "R3"; t_pa[p] = "R3"; t_ln[p] = "R3";
            return;
        end
        lk = r1[2];
        if (e_known[p] && e_prev[p] == lk) begin
            t_rd[p] = "R4"; t_md[p] = "R4"; t_pa[p] = "R4"; t_ln[p] = "R4";
            return;
        end
        t_rd[p] = "R5"; t_md[p] = "R5"; t_pa[p] = "R5"; t_ln[p] = "R5";
        if (!lk) begin
            e_link[p] = 0;
            e_reads[p]++;
            r1 = m_r1b[p];
            lk = r1[2];
        end
        if (lk) begin
            neg = m_r0[p][12] && r1[5];
            e_reads[p] += neg ? 5 : 2;
            e_r9[p] = neg ? 1 : 0;
            m = ref_mode(m_r0[p], r1, m_r4[p], m_r5[p], m_r9[p], m_r10[p]);
            e_spd[p] = m[3:2]; e_dup[p] = m[1]; e_pau[p] = m[0];
            e_link[p] = 1;
            t_rd[p] = neg ? "R6" : "R9";
            t_md[p] = neg ? "R8" : "R9";
            t_pa[p] = neg ? "R7" : "R9";
            t_ln[p] = (t_ln[p] == "R5" && !m_r1a[p][2]) ? "R5" : "R10";
        end
        e_known[p] = 1;
        e_prev[p] = lk;
    endtask

    task automatic set_port(input int p, input bit [15:0] r0, r1a, r1b, r4, r5, r9, r10);
        m_r0[p] = r0; m_r1a[p] = r1a; m_r1b[p] = r1b;
        m_r4[p] = r4; m_r5[p] = r5; m_r9[p] = r9; m_r10[p] = r10;
    endtask

    task automatic run_round();
        round_id++;
        for (int p = 0; p < NP; p++) predict(p);
        do @(negedge clk);
        while (!(mdio_req && int'(mdio_phy) == PHY0 && mdio_reg == 5'd1));
        repeat (300) @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk(reads[p] == e_reads[p] && r9_reads[p] == e_r9[p], t_rd[p], "read count",
                reads[p], e_reads[p]);
            chk(link_up[p] == e_link[p], t_ln[p], "link_up", int'(link_up[p]), int'(e_link[p]));
            chk(port_speed[2*p +: 2] == e_spd[p] && port_duplex[p] == e_dup[p], t_md[p],
                "speed/duplex", int'({port_speed[2*p +: 2], port_duplex[p]}),
                int'({e_spd[p], e_dup[p]}));
            chk(port_pause[p] == e_pau[p], t_pa[p], "pause", int'(port_pause[p]),
                int'(e_pau[p]));
        end
    endtask

    function automatic bit [15:0] rand_stat(input bit lk);
        bit [15:0] v;
        v = 16'($urandom);
        v[15] = 1'b0;
        v[3] = 1'b1;
        v[2] = lk;
        return v;
    endfunction

    initial begin
        int n0;
        void'($urandom(32'd9173));
        for (int p = 0; p < NP; p++) begin
            reads[p] = 0; r9_reads[p] = 0;
        end
        // round A: port0 negotiated 1000M full with pause, port1 absent
        set_port(0, 16'h1000, 16'h0024, 16'h0024, 16'h05E1, 16'h05E1, 16'h0300, 16'h0C00);
        set_port(1, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0, 16'h0, 16'h0, 16'h0);
        repeat (5) @(negedge clk);
        chk(mdio_req == 0 && link_up == 0 && port_speed == 0 && port_duplex == 0 &&
            port_pause == 0, "R12", "outputs in reset", int'(link_up), 0);
        rst_n = 1'b1;
        repeat (PERIOD / 2) @(negedge clk);
        chk(n_req == 0 && link_up == 0 && port_speed == 0 && port_pause == 0, "R12",
            "outputs before first round", n_req, 0);
        run_round();

        // R2: rounds skipped while enable is low
        sw_en = 1'b0;
        n0 = n_req;
        repeat (2 * PERIOD + 100) @(negedge clk);
        chk(n_req == n0, "R2", "requests while disabled", n_req - n0, 0);
        sw_en = 1'b1;

        // round B: port0 latched low then up, forced 100M full with pause;
        // port1 first seen down and stays down
        set_port(0, 16'h2100, 16'h0008, 16'h000C, 16'h0400, 16'h0, 16'h0, 16'h0);
        set_port(1, 16'h0, 16'h0028, 16'h0008, 16'h0, 16'h0, 16'h0, 16'h0);
        run_round();
        // round C: port0 unchanged (still up), port1 up, enabled but incomplete aneg
        set_port(0, 16'h0040, 16'h000C, 16'h000C, 16'h0, 16'h0, 16'h0, 16'h0);
        set_port(1, 16'h1040, 16'h000C, 16'h000C, 16'h05E0, 16'h05E0, 16'h0300, 16'h0C00);
        run_round();

        for (int k = 0; k < 40; k++) begin
            for (int p = 0; p < NP; p++) begin
                int kind;
                kind = $urandom % 6;
                if (kind == 0)
                    set_port(p, 16'($urandom), ($urandom % 2) ? 16'h0000 : 16'hFFFF,
                             16'($urandom), 16'($urandom), 16'($urandom),
                             16'($urandom), 16'($urandom));
                else
                    set_port(p, 16'($urandom), rand_stat(1'($urandom)), rand_stat(1'($urandom)),
                             16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
            end
            run_round();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule